// File: doc/BRIEF.md
# Parity-Checked Stream Input Node

This block is a single ingress port of a multi-channel formatter. An upstream source presents 32-bit words together with a valid strobe and one parity bit per word. The node checks the parity of each word as it is taken in. Words with correct parity go into a small first-in first-out buffer. Words with wrong parity are discarded, and a one-cycle error pulse reports the discard.

Back-pressure runs towards the source through an active-high wait output, which is the inverse of a ready signal. A word transfers on a rising clock edge where valid is high and wait is low. While wait is high, the source holds its data, parity and valid unchanged. Wait is driven combinationally from the buffer's full state, so no word can be taken into a full buffer. When the source has nothing to send, it drives valid, data and parity low, and the node ignores those cycles.

On the downstream side, the formatter sees the oldest buffered word and an empty flag, and it removes that word with a pop strobe. An occupancy count lets the formatter decide whether enough words are present to build a packet.

Top module: `par_chan_node`

## Requirements
- R1: While rst_n is low at a rising edge, the node clears itself. After that edge, out_empty is 1, out_count is 0, in_wait is 0 and par_err is 0, and any words held before are gone.
- R2: On an edge where in_valid is 1, in_wait is 0 and the parity matches, the node appends in_data to the buffer, and out_count rises by one unless a pop happens on the same edge.
- R3: in_wait is 1 exactly when out_count equals DEPTH. While in_wait is 1, no offered word is stored, and out_count never goes above DEPTH.
- R4: The expected parity is the XOR reduction of all 32 bits of in_data, so in_par must equal ^in_data. A captured word whose parity differs is dropped, and out_count does not change because of it.
- R5: par_err is 1 in the single cycle that follows an edge where a word with mismatched parity was captured. It is 0 in every other cycle.
- R6: A cycle with in_valid at 0 stores nothing and raises no error, whatever in_data and in_par carry.
- R7: When out_empty is 0, out_data shows the oldest stored word, and words leave in the order they were stored. A pop on an edge removes that oldest word.
- R8: A pop while out_empty is 1 has no effect: out_count stays 0 and no later word is disturbed.
- R9: A store and a pop on the same edge leave out_count unchanged and keep the word order.
- R10: out_count always equals the number of words stored, and out_empty is 1 exactly when out_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream word present |
| in_data | input | W | Upstream word |
| in_par | input | 1 | Parity bit of in_data (XOR of all bits) |
| in_wait | output | 1 | High when the node cannot take a word (buffer full) |
| par_err | output | 1 | One-cycle pulse after a word with bad parity was dropped |
| out_pop | input | 1 | Remove the oldest buffered word |
| out_data | output | W | Oldest buffered word |
| out_empty | output | 1 | Buffer holds no words |
| out_count | output | $clog2(DEPTH+1) | Number of buffered words |

## Verification
The embedded properties check on every cycle that the buffer is never pushed while full or decremented while empty, and that a simultaneous store and pop keeps the count. They also check that the error pulse only follows a real capture, and that idle cycles without a pop leave the count alone. What the data actually carries can only be shown by the bench's scenarios. That covers the order of words leaving the buffer, the exact parity rule for every bit position, the dropping of bad words, and the clearing effect of a mid-run reset. The bench does this against a queue model over a four-entry configuration.

// File: rtl/node_pkg.sv
package node_pkg;
  localparam int unsigned WORD_W_DEF = 32;
  localparam int unsigned DEPTH_DEF  = 32;

  // Outcome of one upstream cycle
  typedef enum logic [1:0] {
    CAP_NONE = 2'd0,
    CAP_GOOD = 2'd1,
    CAP_BAD  = 2'd2
  } cap_e;
endpackage

// File: rtl/node_parity.sv
module node_parity #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] word,
  input  logic         par_bit,
  output logic         match
);
  logic [W-1:0] fold;

  // Ripple XOR chain built bit by bit
  assign fold[0] = word[0];
  for (genvar i = 1; i < W; i++) begin : g_fold
    assign fold[i] = fold[i-1] ^ word[i];
  end

  assign match = (fold[W-1] == par_bit);
endmodule

// File: rtl/node_fifo.sv
module node_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               pop_data,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R3: the producer must never push into a full buffer
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  // R8: popping an empty buffer leaves it empty
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);

  // R9: simultaneous store and removal keeps occupancy
  p_pass_through_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty && !full) |=> $stable(count));

  // R10: occupancy bounded by depth
  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/par_chan_node.sv
module par_chan_node
  import node_pkg::*;
#(
  parameter int unsigned W     = WORD_W_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [W-1:0]               in_data,
  input  logic                       in_par,
  output logic                       in_wait,
  output logic                       par_err,
  input  logic                       out_pop,
  output logic [W-1:0]               out_data,
  output logic                       out_empty,
  output logic [$clog2(DEPTH+1)-1:0] out_count
);
  logic par_ok;
  logic buf_full;
  cap_e cap;

  node_parity #(.W(W)) u_par (
    .word    (in_data),
    .par_bit (in_par),
    .match   (par_ok)
  );

  always_comb begin
    if (!in_valid || buf_full) cap = CAP_NONE;
    else if (par_ok)           cap = CAP_GOOD;
    else                       cap = CAP_BAD;
  end

  node_fifo #(.W(W), .DEPTH(DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (cap == CAP_GOOD),
    .push_data (in_data),
    .pop       (out_pop),
    .pop_data  (out_data),
    .full      (buf_full),
    .empty     (out_empty),
    .count     (out_count)
  );

  assign in_wait = buf_full;

  always_ff @(posedge clk) begin
    if (!rst_n) par_err <= 1'b0;
    else        par_err <= (cap == CAP_BAD);
  end

  // R5: an error pulse only follows an actual capture
  p_err_after_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> $past(in_valid && !in_wait));

  // R6: idle without pop leaves occupancy alone
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !out_pop) |=> $stable(out_count));

  // R3: while waiting the count cannot grow
  p_wait_no_growth_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |=> (out_count <= $past(out_count)));
endmodule

// File: tb/sim_par_chan_node.sv
module sim_par_chan_node;
  localparam int  W     = 32;
  localparam int  DEPTH = 4;
  localparam int  CW    = $clog2(DEPTH + 1);
  localparam time CLK_P = 10ns;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_par, out_pop;
  logic [W-1:0]  in_data;
  logic          in_wait, par_err, out_empty;
  logic [W-1:0]  out_data;
  logic [CW-1:0] out_count;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] mq[$];
  logic perr_exp = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  par_chan_node #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_par(in_par), .in_wait(in_wait), .par_err(par_err), .out_pop(out_pop),
    .out_data(out_data), .out_empty(out_empty), .out_count(out_count)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare all outputs against the queue model
  task automatic check_state(input string req);
    chk({req, " count"}, W'(out_count), W'(mq.size()));
    chk({req, " empty (R10)"}, W'(out_empty), W'(mq.size() == 0));
    chk({req, " wait (R3)"}, W'(in_wait), W'(mq.size() == DEPTH));
    chk({req, " perr (R5)"}, W'(par_err), W'(perr_exp));
    if (mq.size() > 0) chk({req, " head (R7)"}, out_data, mq[0]);
  endtask

  // One clock cycle: inputs applied at negedge, outputs checked next negedge
  task automatic cyc(input string req, input logic v, input logic [W-1:0] d,
                     input logic p, input logic pp);
    bit full_now, acc, good, popok;
    in_valid = v; in_data = d; in_par = p; out_pop = pp;
    full_now = (mq.size() == DEPTH);
    acc   = v && !full_now;
    good  = acc && (p == ^d);
    popok = pp && (mq.size() > 0);
    @(posedge clk);
    @(negedge clk);
    if (popok) void'(mq.pop_front());
    if (good)  mq.push_back(d);
    perr_exp = acc && !good;
    check_state(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 0; in_data = '0; in_par = 0; out_pop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    mq.delete();
    perr_exp = 1'b0;
    check_state("R1 reset");
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] w;
    @(negedge clk);
    do_reset();

    // R2/R3: fill beyond capacity with good words
    for (int i = 0; i < DEPTH + 3; i++) begin
      w = W'(i + 1) * 32'h9E3779B9;
      cyc("R2 R3 fill", 1, w, ^w, 0);
    end
    // R7/R8: drain in order, then pop while empty
    for (int i = 0; i < DEPTH + 2; i++) cyc("R7 R8 drain", 0, '0, 0, 1);

    // R4/R5: every single-bit word with right and wrong parity
    for (int b = 0; b < W; b++) begin
      w = W'(1) << b;
      cyc("R4 good bit", 1, w, 1'b1, 0);
      cyc("R4 R5 bad bit", 1, w, 1'b0, 1);
      cyc("R5 quiet", 0, '0, 0, 0);
    end
    // R4: all-zero and all-one words, both parities
    cyc("R4 zero ok", 1, '0, 0, 0);
    cyc("R4 zero bad", 1, '0, 1, 0);
    cyc("R4 ones ok", 1, '1, 0, 0);
    cyc("R4 ones bad", 1, '1, 1, 0);
    cyc("R5 back-to-back bad", 1, 32'h0000_0003, 1, 0);
    cyc("R5 back-to-back bad", 1, 32'h0000_0007, 0, 0);
    for (int i = 0; i < DEPTH; i++) cyc("R7 drain", 0, '0, 0, 1);

    // R6: idle cycles with zeros and with garbage on data/parity
    cyc("R6 idle zero", 0, '0, 0, 0);
    for (int i = 0; i < 8; i++) cyc("R6 idle junk", 0, 32'hA5A5_0000 + W'(i), i[0], 0);

    // R9: stream with pop every cycle, then with buffer partly filled
    for (int i = 0; i < 6; i++) begin
      w = 32'h1234_5678 ^ (W'(i) << 7);
      cyc("R9 stream", 1, w, ^w, 1);
    end
    for (int i = 0; i < DEPTH - 1; i++) begin
      w = 32'hC0DE_0000 + W'(i * 17);
      cyc("R2 prefill", 1, w, ^w, 0);
    end
    for (int i = 0; i < 6; i++) begin
      w = 32'h0F0F_0000 | W'(i * 3);
      cyc("R9 push pop", 1, w, ^w, 1);
    end
    // R3: reach full, offer a bad word while full (no error since not captured)
    cyc("R3 to full", 1, 32'h0000_0101, 0, 0);
    cyc("R3 full good", 1, 32'h0000_0001, 1, 0);
    cyc("R3 full bad", 1, 32'h0000_0001, 0, 0);
    cyc("R3 full pop", 1, 32'h0000_0001, 1, 1);

    // R1: reset while holding words
    do_reset();
    cyc("R1 after reset", 0, '0, 0, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule